// File: doc/BRIEF.md
# Endpoint Stall Control Register

This block keeps the forced-stall state of each endpoint of a USB device controller. When a stall bit is set, the handshake logic must answer that endpoint's tokens with a STALL handshake. The block exposes the bits as a registered per-endpoint vector. Software writes and reads the state through a plain 8-bit register port.

Hardware may also clear stall bits on its own:
- Endpoint 0's stall bit clears when a setup command has been received and decoded.
- While the setup-received flag is up, software cannot set endpoint 0's stall bit.
- A single global enable, when set, clears an endpoint's stall bit once a STALL handshake for it has gone to the host.

All ports are control and status levels or single-cycle pulses. There is no streaming data path, so no valid/ready handshake applies. A write takes effect on the clock edge where `reg_wr_en` is high.

Top module: `ep_stall_ctrl`

## Requirements
- R1: Register layout: bits [3:0] hold the stall bits of endpoints 0 to 3 (bit n for endpoint n), bit 4 holds the auto-clear enable, and bits [7:5] always read 0 and ignore written values.
- R2: After reset, `reg_rd_data` reads 0x00 and `ep_stall` is all zero.
- R3: A register write with no concurrent hardware event loads bits [4:0] from `reg_wr_data`. The change appears on `ep_stall` and `reg_rd_data` in the cycle after the write edge.
- R4: `ep_stall` always equals `reg_rd_data[3:0]`.
- R5: A `setup_rcvd` pulse clears the endpoint 0 stall bit on the next edge. This clear wins over a write of 1 to bit 0 in the same cycle, and the other bits are left unchanged.
- R6: While `setup_flag` is 1, a write of 1 to bit 0 leaves the endpoint 0 stall bit unchanged. A write of 0 to bit 0 still clears it, and bits [4:1] of the same write load normally.
- R7: With the auto-clear enable at 1, a pulse on `stall_sent[n]` clears stall bit n on the next edge and leaves every other bit unchanged.
- R8: With the auto-clear enable at 0, pulses on `stall_sent` leave all stall bits unchanged.
- R9: With the auto-clear enable at 1, a write in the same cycle as `stall_sent[n]` wins, and bit n takes the written value.
- R10: The auto-clear enable changes only by register write or reset. Setup pulses and `stall_sent` pulses do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write value |
| reg_rd_data | output | 8 | Register read value |
| setup_rcvd | input | 1 | Pulse: setup command received and decoded |
| setup_flag | input | 1 | Level: setup-received flag is set |
| stall_sent | input | 4 | Pulse per endpoint: STALL handshake returned |
| ep_stall | output | 4 | Per-endpoint stall request to the handshake logic |

## Verification
The properties assume that `setup_rcvd` and `stall_sent` are single-cycle pulses that are synchronous to `clk`. They also assume that no input is unknown once reset is released. The write-load property is qualified so that it applies only when no setup pulse and no setup flag are present. The auto-clear properties are conditioned on the absence of a write. The bench drives every input at the falling edge and returns pulses to 0 after one cycle. It creates overlaps of write and hardware event only on purpose, in the scenarios that test priority.

// File: rtl/ep_stall_pkg.sv
package ep_stall_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_EP   = 4;
  localparam int AUTO_BIT = NUM_EP;
  localparam int USED_W   = NUM_EP + 1;

  // Assemble the readable register image from stored state.
  function automatic logic [REG_W-1:0] make_image(input logic [NUM_EP-1:0] st,
                                                  input logic auto_en);
    logic [REG_W-1:0] img;
    img = '0;
    img[NUM_EP-1:0] = st;
    img[AUTO_BIT]   = auto_en;
    return img;
  endfunction
endpackage

// File: rtl/ep_stall_bit.sv
module ep_stall_bit #(
  parameter bit IS_EP0 = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic setup_pulse,
  input  logic setup_lvl,
  input  logic sent,
  input  logic auto_en,
  output logic stall_q
);
  logic nxt;
  logic wr_blocked;

  // Endpoint 0 rejects setting its stall while the setup flag is up.
  assign wr_blocked = IS_EP0 && setup_lvl && wr_bit;

  always_comb begin
    nxt = stall_q;
    if (auto_en && sent) nxt = 1'b0;          // lowest priority
    if (wr_en && !wr_blocked) nxt = wr_bit;   // software beats auto-clear
    if (IS_EP0 && setup_pulse) nxt = 1'b0;    // setup clear beats software
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= nxt;
  end
endmodule

// File: rtl/ep_stall_autoclr.sv
module ep_stall_autoclr (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic auto_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     auto_en <= 1'b0;
    else if (wr_en) auto_en <= wr_bit;
  end
endmodule

// File: rtl/ep_stall_ctrl.sv
module ep_stall_ctrl
  import ep_stall_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  reg_rd_data,
  input  logic              setup_rcvd,
  input  logic              setup_flag,
  input  logic [NUM_EP-1:0] stall_sent,
  output logic [NUM_EP-1:0] ep_stall
);
  logic              auto_en;
  logic [NUM_EP-1:0] stall_q;

  ep_stall_autoclr u_auto (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_bit  (reg_wr_data[AUTO_BIT]),
    .auto_en (auto_en)
  );

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    ep_stall_bit #(.IS_EP0(g == 0)) u_bit (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_wr_en),
      .wr_bit      (reg_wr_data[g]),
      .setup_pulse (setup_rcvd),
      .setup_lvl   (setup_flag),
      .sent        (stall_sent[g]),
      .auto_en     (auto_en),
      .stall_q     (stall_q[g])
    );
  end

  assign ep_stall    = stall_q;
  assign reg_rd_data = make_image(stall_q, auto_en);
endmodule

// File: rtl/ep_stall_ctrl_chk.sv
module ep_stall_ctrl_chk
  import ep_stall_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [REG_W-1:0]  reg_wr_data,
  input logic [REG_W-1:0]  reg_rd_data,
  input logic              setup_rcvd,
  input logic              setup_flag,
  input logic [NUM_EP-1:0] stall_sent,
  input logic [NUM_EP-1:0] ep_stall
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[REG_W-1:USED_W] == '0);

  assert_out_matches_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ep_stall == reg_rd_data[NUM_EP-1:0]);

  assert_write_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !setup_rcvd && !setup_flag)
      |=> reg_rd_data[USED_W-1:0] == $past(reg_wr_data[USED_W-1:0]));

  assert_setup_clears_ep0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rcvd |=> !ep_stall[0]);

  assert_set_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_flag && reg_wr_en && reg_wr_data[0] && !ep_stall[0]) |=> !ep_stall[0]);

  assert_auto_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[AUTO_BIT] && !reg_wr_en && (|stall_sent))
      |=> (ep_stall & $past(stall_sent)) == '0);

  assert_no_auto_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd_data[AUTO_BIT] && !reg_wr_en && !setup_rcvd) |=> $stable(ep_stall));

  assert_enable_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(reg_rd_data[AUTO_BIT]));
endmodule

bind ep_stall_ctrl ep_stall_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .reg_rd_data (reg_rd_data),
  .setup_rcvd  (setup_rcvd),
  .setup_flag  (setup_flag),
  .stall_sent  (stall_sent),
  .ep_stall    (ep_stall)
);

// File: tb/ep_stall_ctrl_tb.sv
module ep_stall_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic       setup_rcvd = 1'b0;
  logic       setup_flag = 1'b0;
  logic [3:0] stall_sent = '0;
  logic [3:0] ep_stall;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ep_stall_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .setup_rcvd(setup_rcvd), .setup_flag(setup_flag),
    .stall_sent(stall_sent), .ep_stall(ep_stall)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at the falling edge, release it one cycle later.
  task automatic step(logic we, logic [7:0] wd, logic sp, logic [3:0] sent);
    @(negedge clk);
    reg_wr_en = we; reg_wr_data = wd; setup_rcvd = sp; stall_sent = sent;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_data = '0; setup_rcvd = 1'b0; stall_sent = '0;
  endtask

  task automatic t_reset();
    check("R2 read", reg_rd_data, 8'h00);
    check("R2 stall", {4'h0, ep_stall}, 8'h00);
  endtask

  task automatic t_write();
    step(1, 8'hFF, 0, 0);
    check("R1 reserved masked", reg_rd_data, 8'h1F);
    check("R4 out", {4'h0, ep_stall}, 8'h0F);
    step(1, 8'h0A, 0, 0);
    check("R3 load", reg_rd_data, 8'h0A);
    step(1, 8'h15, 0, 0);
    check("R3 load2", reg_rd_data, 8'h15);
    check("R4 out2", {4'h0, ep_stall}, 8'h05);
  endtask

  task automatic t_setup();
    step(1, 8'h0F, 0, 0);
    step(0, 8'h00, 1, 0);
    check("R5 clear ep0", reg_rd_data, 8'h0E);
    check("R10 setup keeps enable", reg_rd_data & 8'h10, 8'h00);
    step(1, 8'h13, 1, 0);
    check("R5 beats write", reg_rd_data, 8'h12);
  endtask

  task automatic t_flag();
    step(1, 8'h00, 0, 0);
    setup_flag = 1'b1;
    step(1, 8'h07, 0, 0);
    check("R6 set ignored", reg_rd_data, 8'h06);
    setup_flag = 1'b0;
    step(1, 8'h01, 0, 0);
    setup_flag = 1'b1;
    step(1, 8'h18, 0, 0);
    check("R6 zero clears", reg_rd_data, 8'h18);
    setup_flag = 1'b0;
  endtask

  task automatic t_auto();
    step(1, 8'h1F, 0, 0);
    step(0, 8'h00, 0, 4'b0100);
    check("R7 clears ep2", reg_rd_data, 8'h1B);
    step(0, 8'h00, 0, 4'b1001);
    check("R7 clears ep0 ep3", reg_rd_data, 8'h12);
    check("R10 enable kept", reg_rd_data & 8'h10, 8'h10);
    step(1, 8'h1F, 0, 4'b0011);
    check("R9 write wins", reg_rd_data, 8'h1F);
  endtask

  task automatic t_noauto();
    step(1, 8'h0F, 0, 0);
    step(0, 8'h00, 0, 4'b1111);
    check("R8 no clear", reg_rd_data, 8'h0F);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_setup();
    t_flag();
    t_auto();
    t_noauto();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule